// File: doc/BRIEF.md
# Eight-Pin Digital I/O Port Controller

This block turns a small set of per-pin configuration bits into the control signals for eight I/O pads. Each pin has a direction bit, an output level bit, a pull-up bit, a pull-down bit and an input-gate bit. One port-wide bit selects a bias mode. From these, the block drives the pad's output enable, output value, pull-up enable, pull-down enable, half-supply bias enable and input gate. It also returns a synchronized and gated copy of each pad level. Interrupt and wake-up logic consumes that copy.

Software reaches the configuration through a plain synchronous bus: a write strobe, an address and a data word. Reads are combinational on the address. The registers have no reset and start unknown, so the system must write every register before it relies on the pads. Writes are accepted while reset is asserted. Reset clears only the input synchronizer.

Top module: `gpio_port8`

## Requirements
- R1: A write with `wr_en` high stores `wdata` on the rising clock edge into the register selected by `addr`: 0 direction, 1 output level, 2 pull-up, 3 pull-down, 4 input gate, 5 bias mode (bit 0 only). Reads of addresses 0, 2, 3 and 4 return the stored byte. Address 5 returns the bias bit in bit 0 with zeros above it. Addresses 6 and 7 read as zero.
- R2: A direction bit of 1 sets that pin's `pad_oe`, and `pad_out` then equals the output level bit. A direction bit of 0 clears `pad_oe`, and changing the output level bit then leaves `pad_oe`, `pad_pu`, `pad_pd`, `pad_bias` and `pad_ie` unchanged.
- R3: `pad_pu` follows the pull-up bit on an input pin. It also follows the pull-up bit on an output pin driven high.
- R4: On an input pin whose input-gate bit is 0, `pad_ie` is 0, `din_gated` is 0 and the level read at address 1 is 0, whatever the pad level.
- R5: On an output pin driven low, `pad_pu` and `pad_pd` are both 0 regardless of the pull bits.
- R6: With bias mode set, `pad_bias` is 1 exactly on the pins that are inputs with pull-up, pull-down and input gate all 0. On those pins `pad_oe`, `pad_pu`, `pad_pd` and `pad_ie` are 0. With bias mode clear, `pad_bias` is 0 on every pin.
- R7: In bias mode an output pin keeps `pad_oe` at 1 with `pad_out` equal to its output level bit, and its `pad_bias` is 0.
- R8: A change on `pad_in` reaches `din_gated` after exactly two rising clock edges. `din_gated` equals the pad level from two edges earlier ANDed with the current `pad_ie`.
- R9: A read of address 1 returns the output level bit for output pins and `din_gated` for input pins.
- R10: While `rst_n` is low the synchronizer holds zero, so `din_gated` is 0 until two rising edges after release, even with all pads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the input synchronizer |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (3) | Register select |
| wdata | input | NPIN (8) | Write data |
| rdata | output | NPIN (8) | Read data for `addr` |
| pad_in | input | NPIN (8) | Raw pad levels |
| pad_oe | output | NPIN (8) | Pad output enable |
| pad_out | output | NPIN (8) | Pad output value |
| pad_pu | output | NPIN (8) | Pull-up enable |
| pad_pd | output | NPIN (8) | Pull-down enable |
| pad_bias | output | NPIN (8) | Half-supply bias enable |
| pad_ie | output | NPIN (8) | Digital input gate |
| din_gated | output | NPIN (8) | Synchronized, gated pad levels for interrupt and wake-up logic |

## Verification
The bench checks each pad control against every other pin configuration at once, so a decode that confuses two pins shows up. It also targets the corner cases a careless decode gets wrong:
- An output driven high with its pull-up bit set. Clearing the pull there would break R3.
- An output driven low with both pull bits set. Leaving either pull on would break R5.
- A pin that is input-gated off while its pad is high. Leaking the level into `din_gated` or into the address-1 read would break R4.
- Bias mode with a mix of gated, pulled and output pins. A design that biases any of those pins, or biases while the mode bit is clear, is caught.
- Synchronizer timing, sampled one edge early and exactly on the second edge. An extra or missing flop is caught.
- The address-1 read mix, where a swapped select returns the wrong half.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int NPIN = 8,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_pu,
  output logic [NPIN-1:0] pad_pd,
  output logic [NPIN-1:0] pad_bias,
  output logic [NPIN-1:0] pad_ie,
  output logic [NPIN-1:0] din_gated
);
  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_LVL  = AW'(1);
  localparam logic [AW-1:0] A_PU   = AW'(2);
  localparam logic [AW-1:0] A_PD   = AW'(3);
  localparam logic [AW-1:0] A_GATE = AW'(4);
  localparam logic [AW-1:0] A_BIAS = AW'(5);

  logic [NPIN-1:0] dir_q, lvl_q, pu_q, pd_q, gate_q;
  logic            bias_q;
  logic [NPIN-1:0] sync1_q, sync2_q;
  logic [NPIN-1:0] drive_low;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (addr)
        A_DIR:  dir_q  <= wdata;
        A_LVL:  lvl_q  <= wdata;
        A_PU:   pu_q   <= wdata;
        A_PD:   pd_q   <= wdata;
        A_GATE: gate_q <= wdata;
        A_BIAS: bias_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign drive_low = dir_q & ~lvl_q;
  assign pad_oe    = dir_q;
  assign pad_out   = lvl_q;
  assign pad_pu    = pu_q & ~drive_low;
  assign pad_pd    = pd_q & ~drive_low;
  assign pad_ie    = gate_q | dir_q;
  assign pad_bias  = {NPIN{bias_q}} & ~dir_q & ~pu_q & ~pd_q & ~gate_q;
  assign din_gated = sync2_q & pad_ie;

  always_comb begin
    case (addr)
      A_DIR:   rdata = dir_q;
      A_LVL:   rdata = (dir_q & lvl_q) | (~dir_q & din_gated);
      A_PU:    rdata = pu_q;
      A_PD:    rdata = pd_q;
      A_GATE:  rdata = gate_q;
      A_BIAS:  rdata = {{(NPIN-1){1'b0}}, bias_q};
      default: rdata = '0;
    endcase
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_dir_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (pad_oe == $past(wdata)));
  p_high_keeps_pu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PU) |=> ((pad_pu & pad_oe & pad_out) == ($past(wdata) & pad_oe & pad_out)));
  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((din_gated & ~pad_ie) == '0));
  p_low_nopull_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_pu | pad_pd) & pad_oe & ~pad_out) == '0));
  p_bias_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_bias & (pad_oe | pad_pu | pad_pd | pad_ie)) == '0));
  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (din_gated == ($past(pad_in, 2) & pad_ie)));
  p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd0) |-> (din_gated == '0));
endmodule

// File: tb/gpio_port8_bench.sv
`timescale 1ns/1ps
module gpio_port8_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] rdata, pad_oe, pad_out, pad_pu, pad_pd, pad_bias, pad_ie, din_gated;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_dir, m_lvl, m_pu, m_pd, m_gate;
  logic       m_bias;

  always #2.5 clk = ~clk;

  gpio_port8 u_gpio_port8 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_bias(pad_bias), .pad_ie(pad_ie),
    .din_gated(din_gated)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: m_dir = d;
      3'd1: m_lvl = d;
      3'd2: m_pu = d;
      3'd3: m_pd = d;
      3'd4: m_gate = d;
      3'd5: m_bias = d[0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic chk_pads(input string tag);
    logic [7:0] low;
    low = m_dir & ~m_lvl;
    chk({tag, " oe"},   pad_oe, m_dir);
    chk({tag, " out"},  pad_out & m_dir, m_lvl & m_dir);
    chk({tag, " pu"},   pad_pu, m_pu & ~low);
    chk({tag, " pd"},   pad_pd, m_pd & ~low);
    chk({tag, " ie"},   pad_ie, m_gate | m_dir);
    chk({tag, " bias"}, pad_bias, {8{m_bias}} & ~m_dir & ~m_pu & ~m_pd & ~m_gate);
  endtask

  task automatic settle_pads(input logic [7:0] v);
    @(negedge clk); pad_in = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    pad_in = 8'hFF;
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd3, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'h00);
    chk("R10 din in reset", din_gated, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 din one edge after release", din_gated, 8'h00);
    @(negedge clk);
    chk("R10 din two edges after release", din_gated, 8'hFF);
    rd(3'd1, d);
    chk("R10 level read", d, 8'hFF);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(3'd0, 8'h3C); rd(3'd0, d); chk("R1 dir read", d, 8'h3C);
    wr(3'd2, 8'h96); rd(3'd2, d); chk("R1 pu read", d, 8'h96);
    wr(3'd3, 8'h41); rd(3'd3, d); chk("R1 pd read", d, 8'h41);
    wr(3'd4, 8'h7E); rd(3'd4, d); chk("R1 gate read", d, 8'h7E);
    wr(3'd5, 8'hFE); rd(3'd5, d); chk("R1 bias read bit0 only", d, 8'h00);
    wr(3'd5, 8'h01); rd(3'd5, d); chk("R1 bias read", d, 8'h01);
    rd(3'd6, d); chk("R1 unmapped 6", d, 8'h00);
    rd(3'd7, d); chk("R1 unmapped 7", d, 8'h00);
    wr(3'd5, 8'h00);
    chk_pads("R1 mixed");
  endtask

  task automatic t_direction;
    logic [7:0] oe0, pu0, pd0, bs0, ie0;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h0F);
    wr(3'd0, 8'h0F); wr(3'd1, 8'hA5);
    chk_pads("R2 dir 0F");
    chk("R2 out value", pad_out & 8'h0F, 8'h05);
    wr(3'd2, 8'hF0);
    oe0 = pad_oe; pu0 = pad_pu; pd0 = pad_pd; bs0 = pad_bias; ie0 = pad_ie;
    wr(3'd1, 8'h55);
    chk("R2 input oe unchanged", pad_oe, oe0);
    chk("R2 input pu unchanged", pad_pu & 8'hF0, pu0 & 8'hF0);
    chk("R2 input pd unchanged", pad_pd & 8'hF0, pd0 & 8'hF0);
    chk("R2 input bias unchanged", pad_bias, bs0);
    chk("R2 input ie unchanged", pad_ie, ie0);
  endtask

  task automatic t_pulls;
    wr(3'd0, 8'hFF); wr(3'd1, 8'hF0); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    chk("R3 pu on output high", pad_pu, 8'hF0);
    chk("R5 pd off on output low", pad_pd & 8'h0F, 8'h00);
    chk_pads("R5 all outputs");
    wr(3'd0, 8'h00);
    chk("R3 pu on inputs", pad_pu, 8'hFF);
    wr(3'd2, 8'h5A);
    chk("R3 pu follows bit on inputs", pad_pu, 8'h5A);
  endtask

  task automatic t_gate;
    logic [7:0] d;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h00); wr(3'd4, 8'h33);
    settle_pads(8'hFF);
    chk("R4 ie", pad_ie, 8'h33);
    chk("R4 din gated", din_gated, 8'h33);
    rd(3'd1, d);
    chk("R4 level read gated", d, 8'h33);
  endtask

  task automatic t_bias;
    wr(3'd0, 8'hC0); wr(3'd1, 8'h80); wr(3'd2, 8'h01); wr(3'd3, 8'h02);
    wr(3'd4, 8'h04); wr(3'd5, 8'h01);
    chk("R6 bias pins", pad_bias, 8'h38);
    chk_pads("R6 bias mix");
    chk("R7 output oe in bias", pad_oe & 8'hC0, 8'hC0);
    chk("R7 output value in bias", pad_out & 8'hC0, 8'h80);
    wr(3'd5, 8'h00);
    chk("R6 bias clear", pad_bias, 8'h00);
  endtask

  task automatic t_sync;
    wr(3'd0, 8'h00); wr(3'd4, 8'hFF); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    settle_pads(8'h00);
    @(negedge clk); pad_in = 8'hC3;
    @(negedge clk);
    chk("R8 one edge", din_gated, 8'h00);
    @(negedge clk);
    chk("R8 two edges", din_gated, 8'hC3);
    @(negedge clk); pad_in = 8'h18;
    @(negedge clk);
    chk("R8 one edge fall", din_gated, 8'hC3);
    @(negedge clk);
    chk("R8 two edges fall", din_gated, 8'h18);
  endtask

  task automatic t_readmix;
    logic [7:0] d;
    wr(3'd0, 8'hF0); wr(3'd1, 8'h5A); wr(3'd4, 8'hFF);
    settle_pads(8'h96);
    rd(3'd1, d);
    chk("R9 level read mix", d, 8'h56);
    chk("R9 din output pins", din_gated, 8'h96);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_direction();
    t_pulls();
    t_gate();
    t_bias();
    t_sync();
    t_readmix();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule